// File: doc/BRIEF.md
# Superfractional LIN Baud Rate Generator

This block produces the bit timing for a LIN/UART serial engine. A character is ten slots long: a start slot, eight data slots (D0 first, D7 last) and a stop slot. The block counts peripheral clocks through each slot. It raises a strobe on the last clock of every slot and a sample strobe at the slot midpoint, and it reports the index of the current slot.

The slot length comes from three values: an integer prescaler P, a 4-bit fractional value M and a 3-bit modulation code. The code names a fixed set of slots that are each stretched by one clock, so that the fractional part is spread evenly over the character. Stretching applies only in LIN operation, and only to the fields that the current role allows. A commander stretches the sync, identifier and response bytes. A responder leaves the sync byte unstretched.

A single-cycle pulse on `char_start_i` begins a character. All configuration inputs are captured at that moment and held until the character ends.

Top module: `lin_baud_gen`

## Requirements
- R1: After reset, `bit_tick_o` and `sample_tick_o` are 0 and `bit_idx_o` is 0. While no character is running, both strobes stay 0 and `bit_idx_o` stays 0.
- R2: When the captured prescaler is 0, every slot lasts exactly 32 clocks, whatever the fractional value, modulation code, mode or field.
- R3: When the captured prescaler P is not 0, an unstretched slot lasts 16*(P+1)+M clocks.
- R4: Slots are numbered 0 = start, 1..8 = D0..D7 and 9 = stop. A stretched slot is one clock longer. The stretched slots for each code are:
  - code 0: none
  - code 1: start, D7
  - code 2: start, D3, D7
  - code 3: start, D1, D3, D7
  - code 4: start, D1, D3, D5, D7
  - code 5: start, D0, D1, D3, D5, D7, stop
  - code 6: code 5 plus D4
  - code 7: code 6 plus D2
- R5: The field encoding is 2'b00 = sync, 2'b01 = identifier, 2'b10 = response, and 2'b11 is treated as response. With `lin_mode_i`=1 and `commander_i`=1, stretching applies to all of these fields.
- R6: With `lin_mode_i`=1 and `commander_i`=0, stretching applies to the identifier and response fields, and never to the sync field.
- R7: With `lin_mode_i`=0, the modulation code has no effect, and only P and M set the slot length.
- R8: `bit_tick_o` is high for exactly the last clock of each slot. `bit_idx_o` steps 0..9 at slot boundaries. After the tick of slot 9, the block goes idle.
- R9: `sample_tick_o` is high exactly once per slot, on the clock at offset floor(L/2) from the slot's first clock, where L is the slot length.
- R10: P, M, the code, the mode, the role and the field are captured at character start. Changes to them during a character have no effect on it.
- R11: After a `char_start_i` pulse, the next clock is the first clock of slot 0. This holds even when the pulse arrives in the middle of a character or on the final tick of the previous character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_start_i | input | 1 | One-cycle pulse that begins a character and captures the configuration |
| presc_i | input | PW | Integer prescaler P |
| frac_i | input | 4 | Fractional value M |
| mod_code_i | input | 3 | Modulation code, 0..7 |
| lin_mode_i | input | 1 | 1 = LIN operation, 0 = plain UART |
| commander_i | input | 1 | 1 = commander role, 0 = responder role |
| field_i | input | 2 | Field type of the character (see R5) |
| bit_tick_o | output | 1 | Last clock of the current slot |
| sample_tick_o | output | 1 | Midpoint clock of the current slot |
| bit_idx_o | output | 4 | Current slot index, 0..9 |

## Verification
The bound checker watches several properties on every cycle:
- the strobes and index stay quiet while idle;
- the index steps by one at each boundary, and the block returns to idle after slot 9;
- the two strobes never coincide;
- a start pulse puts the block at the first clock of slot 0;
- each slot's length falls within the window set by the captured P and M, exactly 32 when P is 0.

Some behaviour depends on the exact per-code stretch pattern, the mode and field gating, and configuration changes made mid-character. Only the bench's scenarios show that behaviour, by measuring every slot length and sample offset against an independently written table.

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_start_i,
  input  logic [PW-1:0] presc_i,
  input  logic [3:0]    frac_i,
  input  logic [2:0]    mod_code_i,
  input  logic          lin_mode_i,
  input  logic          commander_i,
  input  logic [1:0]    field_i,
  output logic          bit_tick_o,
  output logic          sample_tick_o,
  output logic [3:0]    bit_idx_o
);
  localparam int CW = PW + 5;
  localparam logic [3:0] LAST_SLOT = 4'd9;
  localparam logic [1:0] FLD_SYNC = 2'b00;

  logic          active;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [PW-1:0] p_q;
  logic [3:0]    m_q;
  logic [9:0]    mask_q;

  function automatic logic [9:0] code_mask(input logic [2:0] code);
    case (code)
      3'd1:    code_mask = 10'h101;
      3'd2:    code_mask = 10'h111;
      3'd3:    code_mask = 10'h115;
      3'd4:    code_mask = 10'h155;
      3'd5:    code_mask = 10'h357;
      3'd6:    code_mask = 10'h377;
      3'd7:    code_mask = 10'h37F;
      default: code_mask = 10'h000;
    endcase
  endfunction

  wire           mod_on   = lin_mode_i && (commander_i || field_i != FLD_SYNC);
  wire [9:0]     mask_sh  = mask_q >> idx;
  wire           p_zero   = (p_q == '0);
  wire           stretch  = !p_zero && mask_sh[0];
  wire [CW-1:0]  base_len = p_zero ? CW'(32)
                                   : CW'({p_q, 4'b0000}) + CW'(16) + CW'(m_q);
  wire [CW-1:0]  slot_len = base_len + CW'(stretch);
  wire           last_clk = active && (cnt == slot_len - CW'(1));

  assign bit_tick_o    = last_clk;
  assign sample_tick_o = active && (cnt == (slot_len >> 1));
  assign bit_idx_o     = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      p_q    <= '0;
      m_q    <= '0;
      mask_q <= '0;
    end else if (char_start_i) begin
      active <= 1'b1;
      cnt    <= '0;
      idx    <= '0;
      p_q    <= presc_i;
      m_q    <= frac_i;
      mask_q <= mod_on ? code_mask(mod_code_i) : 10'h000;
    end else if (active) begin
      if (last_clk) begin
        cnt <= '0;
        if (idx == LAST_SLOT) begin
          active <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + 4'd1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module lin_baud_gen_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_start_i,
  input logic          bit_tick_o,
  input logic          sample_tick_o,
  input logic [3:0]    bit_idx_o,
  input logic          active,
  input logic [PW-1:0] p_q,
  input logic [3:0]    m_q
);
  localparam int CW = PW + 5;
  logic [CW-1:0] seen;
  wire  [CW-1:0] lo_len = CW'({p_q, 4'b0000}) + CW'(16) + CW'(m_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen <= '0;
    else if (char_start_i || bit_tick_o) seen <= '0;
    else if (active)                   seen <= seen + CW'(1);
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!bit_tick_o && !sample_tick_o && bit_idx_o == 4'd0));

  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_o && bit_idx_o != 4'd9 && !char_start_i) |=> (bit_idx_o == $past(bit_idx_o) + 4'd1));

  a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_o && bit_idx_o == 4'd9 && !char_start_i) |=> !active);

  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_tick_o, sample_tick_o}));

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    char_start_i |=> (active && bit_idx_o == 4'd0 && seen == '0));

  a_r2_p0_len: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_o && p_q == '0) |-> (seen == CW'(31)));

  a_r3_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_o && p_q != '0) |-> (seen + CW'(1) >= lo_len && seen <= lo_len));
endmodule

bind lin_baud_gen lin_baud_gen_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_start_i(char_start_i),
  .bit_tick_o(bit_tick_o), .sample_tick_o(sample_tick_o), .bit_idx_o(bit_idx_o),
  .active(active), .p_q(p_q), .m_q(m_q)
);

// File: tb/test_lin_baud_gen.sv
module test_lin_baud_gen;
  localparam int PW = 8;
  logic clk = 1'b0, rst_n = 1'b0, char_start = 1'b0;
  logic [PW-1:0] presc = '0;
  logic [3:0] frac = '0;
  logic [2:0] code = '0;
  logic lin = 1'b0, cmd = 1'b0;
  logic [1:0] fld = '0;
  logic bit_tick, sample_tick;
  logic [3:0] bit_idx;
  int nchk = 0, nfail = 0, cycles = 0;

  always #4 clk = ~clk;

  lin_baud_gen #(.PW(PW)) i_lin_baud_gen (
    .clk(clk), .rst_n(rst_n), .char_start_i(char_start), .presc_i(presc),
    .frac_i(frac), .mod_code_i(code), .lin_mode_i(lin), .commander_i(cmd),
    .field_i(fld), .bit_tick_o(bit_tick), .sample_tick_o(sample_tick),
    .bit_idx_o(bit_idx));

  // {P, M, code, lin, cmd, field, stretched-slot count, mid-char change}
  localparam int NV = 11;
  localparam int VEC[NV][8] = '{
    '{1, 0, 0, 1, 1, 0, 0, 0},  // R3 base only
    '{1, 5, 1, 1, 1, 1, 2, 0},  // R4 code1, R5 ident
    '{2, 3, 5, 1, 0, 2, 7, 0},  // R4 code5, R6 responder response
    '{0, 9, 7, 1, 1, 2, 0, 0},  // R2 P=0
    '{1, 15, 7, 1, 0, 0, 0, 0}, // R6 responder sync unstretched
    '{1, 2, 6, 1, 1, 0, 8, 0},  // R5 commander sync stretched
    '{3, 1, 4, 0, 1, 2, 0, 0},  // R7 UART ignores code
    '{1, 0, 2, 1, 0, 1, 3, 0},  // R4 code2
    '{1, 0, 3, 1, 1, 3, 4, 0},  // R4 code3, R5 field 11
    '{2, 7, 7, 1, 1, 1, 9, 0},  // R4 code7
    '{1, 0, 0, 1, 1, 0, 0, 1}   // R10 change mid-character
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit stretched(input int c, input int slot);
    case (slot)
      0, 8:    return c >= 1;
      4:       return c >= 2;
      2:       return c >= 3;
      6:       return c >= 4;
      1, 9:    return c >= 5;
      5:       return c >= 6;
      3:       return c >= 7;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_len(input int p, input int m, input int c, input int l,
                                 input int cm, input int f, input int slot);
    bit on;
    if (p == 0) return 32;
    on = (l != 0) && (cm != 0 || f != 0);
    return 16 * (p + 1) + m + ((on && stretched(c, slot)) ? 1 : 0);
  endfunction

  task automatic pulse_start();
    char_start = 1'b1;
    @(negedge clk);
    char_start = 1'b0;
  endtask

  task automatic measure_slot(input string req, input int slot, input int exp, output int len);
    int samp = -1;
    bit idx_ok = 1'b1, tk;
    len = 0;
    do begin
      if (bit_idx != 4'(slot)) idx_ok = 1'b0;
      if (sample_tick) samp = len;
      len++;
      tk = bit_tick;
      @(negedge clk);
    end while (!tk && len < 5000);
    check(len == exp, req, len, exp);
    check(samp == exp / 2, "R9 sample offset", samp, exp / 2);
    check(idx_ok, "R8 slot index", slot, slot);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int len, total, e, base;
    repeat (3) @(negedge clk);
    check(!bit_tick && !sample_tick && bit_idx == 0, "R1 reset state", int'(bit_idx), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!bit_tick && !sample_tick && bit_idx == 0, "R1 idle after reset", int'(bit_tick), 0);

    for (int v = 0; v < NV; v++) begin
      presc = PW'(VEC[v][0]); frac = 4'(VEC[v][1]); code = 3'(VEC[v][2]);
      lin = VEC[v][3] != 0; cmd = VEC[v][4] != 0; fld = 2'(VEC[v][5]);
      pulse_start();
      if (VEC[v][7] != 0) begin
        presc = 8'd2; frac = 4'd7; code = 3'd7; lin = 1'b1; cmd = 1'b1; fld = 2'b10;
      end
      total = 0;
      for (int s = 0; s < 10; s++) begin
        e = exp_len(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], s);
        measure_slot("R2/R3/R4/R5/R6/R7/R10 slot length", s, e, len);
        total += len;
      end
      base = (VEC[v][0] == 0) ? 32 : 16 * (VEC[v][0] + 1) + VEC[v][1];
      check(total == 10 * base + VEC[v][6], "R4 character length", total, 10 * base + VEC[v][6]);
      repeat (4) begin
        check(!bit_tick && !sample_tick && bit_idx == 0, "R8 idle after stop", int'(bit_idx), 0);
        @(negedge clk);
      end
    end

    // R11: restart in the middle of a character
    presc = 8'd1; frac = 4'd0; code = 3'd0; lin = 1'b1; cmd = 1'b1; fld = 2'b01;
    pulse_start();
    while (bit_idx != 4'd3) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_start();
    check(bit_idx == 0, "R11 mid restart index", int'(bit_idx), 0);
    measure_slot("R11 slot0 after restart", 0, 32, len);

    // R11: start on the final tick gives a seamless next character
    while (!(bit_tick && bit_idx == 4'd9)) @(negedge clk);
    presc = 8'd2; frac = 4'd1;
    pulse_start();
    check(bit_idx == 0 && !bit_tick, "R11 back-to-back index", int'(bit_idx), 0);
    measure_slot("R11 back-to-back slot0", 0, 49, len);
    while (!(bit_tick && bit_idx == 4'd9)) @(negedge clk);
    @(negedge clk);
    check(!bit_tick && bit_idx == 0, "R8 idle after back-to-back", int'(bit_idx), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule